// File: doc/BRIEF.md
# Memory-Mapped IDE Register Bridge

This block connects a simple single-cycle host bus to the register interface of an IDE drive. It decodes a 4 KB address window, in which each register occupies a 16-byte slot. Byte accesses reach the seven task-file registers and the device-control / alternate-status register. Halfword and word accesses reach the 16/32-bit data port, and their bytes are reversed in both directions. Any access that lands outside the mapped slots is dropped on a write, and on a read it returns all ones at the access width.

The request is decoded in the cycle it is presented, and the IDE-side strobe is combinational from it. The target's read data is captured into a response register, so read data appears one clock after the request and stays there until the next read. Only one access is ever outstanding. The bridge's own reset is also driven out as the reset of the attached IDE bus.

Top module: `mmio_ide_bridge`

## Requirements
- R1: The register index is address bits [11:4]. Bits above bit 11 and below bit 4 do not affect decoding, so the window repeats every 4 KB.
- R2: A byte access (size 0) at index 1..7 strobes the IDE side with port code 0 (task file) and register number equal to the index.
- R3: A byte access at index 8 or index 22 strobes port code 1. A write there lands in the device-control register, and a read returns the alternate status byte.
- R4: A byte read at any other index returns 0x000000FF. A byte write there raises no strobe and changes no target register.
- R5: A halfword (size 1) or word (size 2) access at index 0 strobes port code 2 (data port). The width flag is 1 for a word and 0 for a halfword.
- R6: Data-port traffic is byte-reversed in both directions. On a halfword access, host bits [7:0] map to IDE bits [15:8]. On a word access, host byte 0 maps to IDE byte 3.
- R7: A halfword read at a non-zero index returns 0x0000FFFF, and a word read there returns 0xFFFFFFFF. Writes at those indices raise no strobe.
- R8: Size code 3 is never mapped. A read returns 0xFFFFFFFF, and a write raises no strobe.
- R9: The read-valid flag is high exactly in the cycle after a read request. The read data then holds its value until the next read.
- R10: The IDE reset output is low whenever the bridge reset is low.
- R11: Out of reset, the read-valid flag is low and the read data is zero.
- R12: Byte-wide task-file and status reads zero-extend the low target byte and ignore target bits [31:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| size | input | 2 | 0 byte, 1 halfword, 2 word, 3 unmapped |
| addr | input | ADDR_W | Host byte address |
| wdata | input | 32 | Host write data, right-aligned |
| rvalid | output | 1 | Read data valid, one cycle after a read request |
| rdata | output | 32 | Registered read data |
| ide_rst_n | output | 1 | Reset to the attached IDE bus |
| ide_stb | output | 1 | IDE register access strobe |
| ide_we | output | 1 | IDE write enable |
| ide_port | output | 2 | 0 task file, 1 control/status, 2 data |
| ide_reg | output | 3 | Task-file register number |
| ide_dwidth | output | 1 | Data-port width, 1 = 32-bit |
| ide_wdata | output | 32 | Write data toward the IDE target |
| ide_rdata | input | 32 | Read data from the IDE target |

## Verification
The bench builds the bridge with the default 16-bit address, a 12-bit window and a 4-bit slot stride. The top four address bits and the low nibble are randomised, which exercises window aliasing and in-slot offsets. The 8-bit index reaches the second control alias at 22 as well as indices beyond it. The target model drives junk in the upper read bits, so any failure to zero-extend byte reads is exposed.

// File: rtl/mmio_ide_pkg.sv
package mmio_ide_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    PORT_TF   = 2'd0,
    PORT_CS   = 2'd1,
    PORT_DATA = 2'd2,
    PORT_NONE = 2'd3
  } ide_port_e;
endpackage

// File: rtl/ide_lane_swap.sv
module ide_lane_swap #(
  parameter int BYTES = 4
) (
  input  logic [8*BYTES-1:0] d,
  output logic [8*BYTES-1:0] q
);
  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    assign q[8*g +: 8] = d[8*(BYTES-1-g) +: 8];
  end
endmodule

// File: rtl/ide_addr_decode.sv
module ide_addr_decode
  import mmio_ide_pkg::*;
#(
  parameter int IDX_W      = 8,
  parameter int CS_IDX_A   = 8,
  parameter int CS_IDX_B   = 22,
  parameter int TF_FIRST   = 1,
  parameter int TF_LAST    = 7,
  parameter int DATA_IDX   = 0
) (
  input  logic [1:0]       size,
  input  logic [IDX_W-1:0] idx,
  output ide_port_e        port,
  output logic [2:0]       reg_sel
);
  localparam logic [IDX_W-1:0] LO_TF = IDX_W'(TF_FIRST);
  localparam logic [IDX_W-1:0] HI_TF = IDX_W'(TF_LAST);
  localparam logic [IDX_W-1:0] CS_A  = IDX_W'(CS_IDX_A);
  localparam logic [IDX_W-1:0] CS_B  = IDX_W'(CS_IDX_B);
  localparam logic [IDX_W-1:0] DIDX  = IDX_W'(DATA_IDX);

  always_comb begin
    port    = PORT_NONE;
    reg_sel = 3'd0;
    unique case (acc_size_e'(size))
      SZ_BYTE: begin
        if (idx >= LO_TF && idx <= HI_TF) begin
          port    = PORT_TF;
          reg_sel = idx[2:0];
        end else if (idx == CS_A || idx == CS_B) begin
          port = PORT_CS;
        end
      end
      SZ_HALF, SZ_WORD: begin
        if (idx == DIDX) port = PORT_DATA;
      end
      default: port = PORT_NONE;
    endcase
  end
endmodule

// File: rtl/ide_resp_reg.sv
module ide_resp_reg #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] data_in,
  output logic          valid_q,
  output logic [DW-1:0] data_q
);
  logic          valid_d;
  logic [DW-1:0] data_d;

  always_comb begin
    valid_d = load;
    data_d  = data_q;
    if (load) data_d = data_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      data_q  <= data_d;
    end
  end
endmodule

// File: rtl/mmio_ide_bridge.sv
module mmio_ide_bridge
  import mmio_ide_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int WIN_BITS    = 12,
  parameter int STRIDE_BITS = 4,
  parameter int CS_IDX_A    = 8,
  parameter int CS_IDX_B    = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic              rvalid,
  output logic [31:0]       rdata,
  output logic              ide_rst_n,
  output logic              ide_stb,
  output logic              ide_we,
  output logic [1:0]        ide_port,
  output logic [2:0]        ide_reg,
  output logic              ide_dwidth,
  output logic [31:0]       ide_wdata,
  input  logic [31:0]       ide_rdata
);
  localparam int IDX_W = WIN_BITS - STRIDE_BITS;

  logic [IDX_W-1:0] idx;
  ide_port_e        port;
  logic [2:0]       reg_sel;
  logic [15:0]      wr_h_sw, rd_h_sw;
  logic [31:0]      wr_w_sw, rd_w_sw;
  logic [31:0]      rd_next;
  logic             rd_load;

  assign idx = addr[WIN_BITS-1:STRIDE_BITS];

  ide_addr_decode #(
    .IDX_W(IDX_W), .CS_IDX_A(CS_IDX_A), .CS_IDX_B(CS_IDX_B),
    .TF_FIRST(1), .TF_LAST(7), .DATA_IDX(0)
  ) u_dec (
    .size(size), .idx(idx), .port(port), .reg_sel(reg_sel)
  );

  ide_lane_swap #(.BYTES(2)) u_sw_wh (.d(wdata[15:0]),     .q(wr_h_sw));
  ide_lane_swap #(.BYTES(4)) u_sw_ww (.d(wdata),           .q(wr_w_sw));
  ide_lane_swap #(.BYTES(2)) u_sw_rh (.d(ide_rdata[15:0]), .q(rd_h_sw));
  ide_lane_swap #(.BYTES(4)) u_sw_rw (.d(ide_rdata),       .q(rd_w_sw));

  assign ide_rst_n  = rst_n;
  assign ide_stb    = req && (port != PORT_NONE);
  assign ide_we     = we;
  assign ide_port   = port;
  assign ide_reg    = reg_sel;
  assign ide_dwidth = (acc_size_e'(size) == SZ_WORD);

  always_comb begin
    unique case (acc_size_e'(size))
      SZ_BYTE: ide_wdata = {24'd0, wdata[7:0]};
      SZ_HALF: ide_wdata = {16'd0, wr_h_sw};
      default: ide_wdata = wr_w_sw;
    endcase
  end

  always_comb begin
    if (port == PORT_TF || port == PORT_CS) begin
      rd_next = {24'd0, ide_rdata[7:0]};
    end else if (port == PORT_DATA) begin
      rd_next = (acc_size_e'(size) == SZ_HALF) ? {16'd0, rd_h_sw} : rd_w_sw;
    end else begin
      unique case (acc_size_e'(size))
        SZ_BYTE: rd_next = 32'h0000_00FF;
        SZ_HALF: rd_next = 32'h0000_FFFF;
        default: rd_next = 32'hFFFF_FFFF;
      endcase
    end
  end

  assign rd_load = req && !we;

  ide_resp_reg #(.DW(32)) u_resp (
    .clk(clk), .rst_n(rst_n), .load(rd_load), .data_in(rd_next),
    .valid_q(rvalid), .data_q(rdata)
  );
endmodule

// File: rtl/mmio_ide_bridge_chk.sv
module mmio_ide_bridge_chk #(
  parameter int ADDR_W      = 16,
  parameter int WIN_BITS    = 12,
  parameter int STRIDE_BITS = 4,
  parameter int CS_IDX_A    = 8,
  parameter int CS_IDX_B    = 22
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic              we,
  input logic [1:0]        size,
  input logic [ADDR_W-1:0] addr,
  input logic              rvalid,
  input logic [31:0]       rdata,
  input logic              ide_rst_n,
  input logic              ide_stb,
  input logic [1:0]        ide_port,
  input logic [31:0]       ide_rdata
);
  localparam int IDX_W = WIN_BITS - STRIDE_BITS;
  logic [IDX_W-1:0] cidx;
  logic             byte_hole;
  assign cidx = addr[WIN_BITS-1:STRIDE_BITS];
  assign byte_hole = (size == 2'd0) && !(cidx >= IDX_W'(1) && cidx <= IDX_W'(7))
                     && cidx != IDX_W'(CS_IDX_A) && cidx != IDX_W'(CS_IDX_B);

  p_rvalid_after_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we) |=> rvalid);
  p_no_rvalid_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req && !we) |=> !rvalid);
  p_rsvd_no_stb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req && size == 2'd3) |-> !ide_stb);
  p_data_port_wide_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ide_stb && ide_port == 2'd2) |-> (size == 2'd1 || size == 2'd2));
  p_byte_hole_ff_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we && byte_hole) |=> (rdata == 32'h0000_00FF));
  p_word_swap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we && size == 2'd2 && cidx == '0) |=>
    (rdata == {$past(ide_rdata[7:0]), $past(ide_rdata[15:8]),
               $past(ide_rdata[23:16]), $past(ide_rdata[31:24])}));
  p_ide_reset_r10: assert property (@(posedge clk) !rst_n |-> !ide_rst_n);
endmodule

bind mmio_ide_bridge mmio_ide_bridge_chk #(
  .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .STRIDE_BITS(STRIDE_BITS),
  .CS_IDX_A(CS_IDX_A), .CS_IDX_B(CS_IDX_B)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .we(we), .size(size), .addr(addr),
  .rvalid(rvalid), .rdata(rdata), .ide_rst_n(ide_rst_n), .ide_stb(ide_stb),
  .ide_port(ide_port), .ide_rdata(ide_rdata)
);

// File: tb/test_mmio_ide_bridge.sv
module test_mmio_ide_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  size = 2'd0;
  logic [15:0] addr = 16'd0;
  logic [31:0] wdata = 32'd0;
  logic        rvalid, ide_rst_n, ide_stb, ide_we, ide_dwidth;
  logic [31:0] rdata, ide_wdata, ide_rdata;
  logic [1:0]  ide_port;
  logic [2:0]  ide_reg;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #4 clk = ~clk;

  mmio_ide_bridge i_mmio_ide_bridge (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .size(size), .addr(addr),
    .wdata(wdata), .rvalid(rvalid), .rdata(rdata), .ide_rst_n(ide_rst_n),
    .ide_stb(ide_stb), .ide_we(ide_we), .ide_port(ide_port), .ide_reg(ide_reg),
    .ide_dwidth(ide_dwidth), .ide_wdata(ide_wdata), .ide_rdata(ide_rdata)
  );

  // Target model: task file, control byte, data latch. Status = ctrl ^ 0x50.
  logic [7:0]  tf_m [0:7];
  logic [7:0]  ctrl_m;
  logic [31:0] data_m;

  always_ff @(posedge clk or negedge ide_rst_n) begin
    if (!ide_rst_n) begin
      for (int i = 0; i < 8; i++) tf_m[i] <= 8'(i * 17);
      ctrl_m <= 8'h00;
      data_m <= 32'h0;
    end else if (ide_stb && ide_we) begin
      case (ide_port)
        2'd0: tf_m[ide_reg] <= ide_wdata[7:0];
        2'd1: ctrl_m <= ide_wdata[7:0];
        2'd2: if (ide_dwidth) data_m <= ide_wdata;
              else data_m[15:0] <= ide_wdata[15:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (ide_port)
      2'd0:    ide_rdata = {24'hA5C3E7, tf_m[ide_reg]};
      2'd1:    ide_rdata = {24'h5A3C7E, ctrl_m ^ 8'h50};
      2'd2:    ide_rdata = data_m;
      default: ide_rdata = 32'hDEAD_BEEF;
    endcase
  end

  // Shadow state computed from the requirements
  logic [7:0]  tf_s [0:7];
  logic [7:0]  ctrl_s;
  logic [31:0] data_s;

  task automatic shadow_reset();
    for (int i = 0; i < 8; i++) tf_s[i] = 8'(i * 17);
    ctrl_s = 8'h00;
    data_s = 32'h0;
  endtask

  function automatic logic [15:0] sw16(input logic [15:0] v);
    return {v[7:0], v[15:8]};
  endfunction
  function automatic logic [31:0] sw32(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  function automatic int kind_of(input logic [15:0] a, input logic [1:0] s);
    logic [7:0] ix = a[11:4];
    if (s == 2'd0 && ix >= 8'd1 && ix <= 8'd7) return 0;
    if (s == 2'd0 && (ix == 8'd8 || ix == 8'd22)) return 1;
    if ((s == 2'd1 || s == 2'd2) && ix == 8'd0) return 2;
    return 3;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [15:0] a, input logic [1:0] s);
    case (kind_of(a, s))
      0: return {24'd0, tf_s[a[6:4]]};
      1: return {24'd0, ctrl_s ^ 8'h50};
      2: return (s == 2'd1) ? {16'd0, sw16(data_s[15:0])} : sw32(data_s);
      default: return (s == 2'd0) ? 32'hFF : (s == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endcase
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [15:0] a, input logic [1:0] s,
                        input logic [31:0] d);
    int k;
    logic [31:0] e;
    k = kind_of(a, s);
    e = exp_rd(a, s);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; size = s; wdata = d;
    #1;
    chk(k == 3 ? "R4/R7/R8 strobe" : "R2/R3/R5 strobe", {31'd0, ide_stb}, {31'd0, k != 3});
    if (k != 3) chk("R1/R2/R3/R5 port", {30'd0, ide_port}, k[1:0]);
    if (k == 0) chk("R2 reg", {29'd0, ide_reg}, {29'd0, a[6:4]});
    if (k == 2) chk("R5 width", {31'd0, ide_dwidth}, {31'd0, s == 2'd2});
    if (w && k == 2)
      chk("R6 write swap", ide_wdata, s == 2'd1 ? {16'd0, sw16(d[15:0])} : sw32(d));
    @(negedge clk);
    req = 1'b0;
    chk("R9 rvalid", {31'd0, rvalid}, {31'd0, !w});
    if (!w) chk("R1/R4/R6/R7/R8/R12 rdata", rdata, e);
    if (w) begin
      case (k)
        0: tf_s[a[6:4]] = d[7:0];
        1: ctrl_s = d[7:0];
        2: if (s == 2'd2) data_s = sw32(d); else data_s[15:0] = sw16(d[15:0]);
        default: ;
      endcase
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      finish_run();
    end
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'h1DE5EED));
    shadow_reset();
    repeat (3) @(negedge clk);
    chk("R11 rvalid reset", {31'd0, rvalid}, 32'd0);
    chk("R11 rdata reset", rdata, 32'd0);
    chk("R10 ide reset", {31'd0, ide_rst_n}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 ide reset release", {31'd0, ide_rst_n}, 32'd1);

    // Directed corners
    access(1'b1, 16'h0030, 2'd0, 32'hFFFF_FF3C);      // R2 task file write
    access(1'b0, 16'hF03A, 2'd0, 32'h0);              // R1 alias read, R12 zero-extend
    access(1'b1, 16'h0165, 2'd0, 32'h0000_0021);      // R3 ctrl via index 22
    access(1'b0, 16'h0080, 2'd0, 32'h0);              // R3 status via index 8
    access(1'b1, 16'h0090, 2'd0, 32'h0000_00AB);      // R4 hole write dropped
    access(1'b0, 16'h0000, 2'd0, 32'h0);              // R4 index 0 byte read
    access(1'b1, 16'h0000, 2'd2, 32'h1122_3344);      // R6 word write
    access(1'b0, 16'h5004, 2'd2, 32'h0);              // R6 word read
    access(1'b1, 16'h0002, 2'd1, 32'h0000_A1B2);      // R6 half write
    access(1'b0, 16'h0000, 2'd1, 32'h0);              // R6 half read
    access(1'b0, 16'h0010, 2'd1, 32'h0);              // R7 half hole
    access(1'b0, 16'h0010, 2'd2, 32'h0);              // R7 word hole
    access(1'b1, 16'h0020, 2'd2, 32'hCAFE_F00D);      // R7 write dropped
    access(1'b0, 16'h0000, 2'd3, 32'h0);              // R8 reserved read
    access(1'b1, 16'h0000, 2'd3, 32'h9999_9999);      // R8 reserved write
    access(1'b0, 16'h0000, 2'd2, 32'h0);              // R7/R8 data unchanged

    // R9 hold across idle cycles
    access(1'b0, 16'h0070, 2'd0, 32'h0);
    held = rdata;
    repeat (2) @(negedge clk);
    chk("R9 rvalid idle", {31'd0, rvalid}, 32'd0);
    chk("R9 rdata hold", rdata, held);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      logic [7:0]  ix;
      int pick;
      pick = $urandom_range(0, 3);
      ix = (pick == 0) ? 8'($urandom_range(0, 9)) :
           (pick == 1) ? 8'(22) :
           (pick == 2) ? 8'($urandom_range(0, 31)) : 8'($urandom);
      a = {4'($urandom), ix, 4'($urandom)};
      access(1'($urandom), a, 2'($urandom), $urandom);
    end

    // R10 mid-run reset clears the attached target
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R10 ide reset mid", {31'd0, ide_rst_n}, 32'd0);
    chk("R11 rvalid mid reset", {31'd0, rvalid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    shadow_reset();
    access(1'b0, 16'h0050, 2'd0, 32'h0);
    access(1'b0, 16'h0080, 2'd0, 32'h0);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule